// File: doc/BRIEF.md
# Extended Load/Store Address Generator

This block forms the memory address for three extended load/store formats of a small embedded core. It takes the two halfwords of a 32-bit instruction and the values already read from the base and offset registers. It recognises a two-offset format, in which base, a scaled index and a signed 8-bit constant are summed, and a second format family. That family either subtracts the index from the base, or adds a shifted index and then bumps the index register by a small constant once the access is done.

A mode bit from the status register gates all of this. With the bit clear, or for any other opcode, the block stays silent. For a recognised instruction it registers a memory request one cycle after the input strobe. The request carries the address, the transfer size, the direction and the three register indices. For the post-update form it also holds the updated index value. That value is offered as a register-file write only in the cycle after the memory side reports completion.

Top module: `lsAddrGen`

## Requirements
- R1: After reset, `outValid` and `wbValid` are 0.
- R2: Two-offset format: `hwFirst[15:12]=1100` and `hwFirst[7]=1`. Fields: scale in `hwFirst[11:10]`, add/sub bit in `hwFirst[9]`, size in `hwFirst[6:5]`, load bit in `hwFirst[4]`, base index in `hwFirst[3:0]`, Rt in `hwSecond[15:12]`, imm8 in `hwSecond[11:4]`, Rm in `hwSecond[3:0]`. With the add/sub bit at 1, `effAddr = base + (offset << scale) + imm8`.
- R3: In the two-offset format with the add/sub bit at 0, the immediate is subtracted: `effAddr = base + (offset << scale) - imm8`.
- R4: Scale value 0 applies no shift. Values 1, 2 and 3 shift the offset left by that many bits.
- R5: Second family: `hwFirst[15:10]=101001` and `hwFirst[9]=0`, with the same size, load and base fields as R2. With `hwSecond[11]=0` the result is `effAddr = base - offset`, and the shift and increment bits have no effect.
- R6: With `hwSecond[11]=1` (post-update), `effAddr = base + (offset << hwSecond[10:8])`.
- R7: In post-update, one cycle after the cycle in which `memDone` is high, `wbValid` is high for exactly one cycle with `wbIdx = hwSecond[3:0]` and `wbData = offset + hwSecond[7:4]`. `wbValid` stays low before `memDone`.
- R8: No writeback is issued for the two-offset or negative formats, even when `memDone` pulses.
- R9: With `extEnable` at 0, or for a non-matching opcode, `outValid` stays 0.
- R10: `outValid` rises one cycle after a valid recognised input. On that cycle size, load bit, Rt, base index and Rm appear unchanged on their outputs.
- R11: All address and increment arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Instruction and operands present |
| extEnable | input | 1 | Status-register extension mode bit |
| hwFirst | input | 16 | First instruction halfword |
| hwSecond | input | 16 | Second instruction halfword |
| baseVal | input | ADDR_W | Base register value |
| offVal | input | ADDR_W | Offset (index) register value |
| memDone | input | 1 | Memory access completed pulse |
| outValid | output | 1 | Memory request valid |
| effAddr | output | ADDR_W | Effective address |
| xferSize | output | 2 | Transfer size, passed through |
| isLoad | output | 1 | 1 for load, 0 for store |
| rtIdx | output | 4 | Data register index |
| rnIdx | output | 4 | Base register index |
| rmIdx | output | 4 | Offset register index |
| wbValid | output | 1 | Offset register writeback strobe |
| wbIdx | output | 4 | Writeback register index |
| wbData | output | ADDR_W | Updated offset value |

## Verification
The bench builds the block with its default ADDR_W of 32. At that width, bases near the top of the address space and a zero base with a positive subtrahend both reach the wrap point of the adder chain. Directed scenarios cover each format, each scale value and a three-bit shift of 3. They also cover the completion handshake, including a completion pulse while no post-update is pending.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture a request this cycle
    logic selTwo;    // two-offset address
    logic selNeg;    // negated offset address
    logic selPost;   // post-update address
    logic fireWb;    // emit writeback next cycle
  } lsagCtl_t;
endpackage

// File: rtl/lsagCtrl.sv
module lsagCtrl
  import lsag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        extEnable,
  input  logic [15:0] hwFirst,
  input  logic [15:0] hwSecond,
  input  logic        memDone,
  output lsagCtl_t    ctl
);
  logic isTwo, isFam, pending;

  always_comb begin
    isTwo = (hwFirst[15:12] == 4'b1100) && hwFirst[7];
    isFam = (hwFirst[15:10] == 6'b101001) && !hwFirst[9];
    ctl.loadReq = inValid && extEnable && (isTwo || isFam);
    ctl.selTwo  = isTwo;
    ctl.selNeg  = isFam && !hwSecond[11];
    ctl.selPost = isFam && hwSecond[11];
    ctl.fireWb  = pending && memDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else if (ctl.loadReq && ctl.selPost) pending <= 1'b1;
    else if (memDone) pending <= 1'b0;
  end

  // R7/R8: a pending writeback only starts from an accepted post-update input
  p_pend_from_post_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(inValid && extEnable && hwSecond[11]));
endmodule

// File: rtl/lsagPath.sv
module lsagPath
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsagCtl_t          ctl,
  input  logic [15:0]       hwFirst,
  input  logic [15:0]       hwSecond,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offVal,
  input  logic              memDone,
  input  logic              extEnable,
  input  logic              inValid,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [1:0]        xferSize,
  output logic              isLoad,
  output logic [3:0]        rtIdx,
  output logic [3:0]        rnIdx,
  output logic [3:0]        rmIdx,
  output logic              wbValid,
  output logic [3:0]        wbIdx,
  output logic [ADDR_W-1:0] wbData
);
  localparam int IMM8_PAD = ADDR_W - 8;
  localparam int IMM4_PAD = ADDR_W - 4;

  logic [ADDR_W-1:0] scaledTwo, scaledPost, imm8Ext, imm4Ext;
  logic [ADDR_W-1:0] addrTwo, addrNeg, addrPost, addrSel, incNext;
  logic [ADDR_W-1:0] pendData;
  logic [3:0]        pendIdx;

  always_comb begin
    scaledTwo  = offVal << hwFirst[11:10];
    scaledPost = offVal << hwSecond[10:8];
    imm8Ext    = {{IMM8_PAD{1'b0}}, hwSecond[11:4]};
    imm4Ext    = {{IMM4_PAD{1'b0}}, hwSecond[7:4]};
    addrTwo    = hwFirst[9] ? (baseVal + scaledTwo + imm8Ext)
                            : (baseVal + scaledTwo - imm8Ext);
    addrNeg    = baseVal - offVal;
    addrPost   = baseVal + scaledPost;
    incNext    = offVal + imm4Ext;
    if (ctl.selTwo)      addrSel = addrTwo;
    else if (ctl.selNeg) addrSel = addrNeg;
    else                 addrSel = addrPost;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      effAddr  <= '0;
      xferSize <= '0;
      isLoad   <= 1'b0;
      rtIdx    <= '0;
      rnIdx    <= '0;
      rmIdx    <= '0;
      pendIdx  <= '0;
      pendData <= '0;
      wbValid  <= 1'b0;
      wbIdx    <= '0;
      wbData   <= '0;
    end else begin
      outValid <= ctl.loadReq;
      wbValid  <= ctl.fireWb;
      if (ctl.loadReq) begin
        effAddr  <= addrSel;
        xferSize <= hwFirst[6:5];
        isLoad   <= hwFirst[4];
        rnIdx    <= hwFirst[3:0];
        rtIdx    <= hwSecond[15:12];
        rmIdx    <= hwSecond[3:0];
        if (ctl.selPost) begin
          pendIdx  <= hwSecond[3:0];
          pendData <= incNext;
        end
      end
      if (ctl.fireWb) begin
        wbIdx  <= pendIdx;
        wbData <= pendData;
      end
    end
  end

  // R9/R10: a request only follows an enabled, valid input
  p_valid_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid && extEnable));
  // R7: writeback only in the cycle after a completion pulse
  p_wb_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(memDone));
  // R5: negated offset address relation at the ports
  p_neg_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadReq && ctl.selNeg) |=> (effAddr == $past(baseVal - offVal)));
  // format selects are mutually exclusive
  p_sel_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.selTwo, ctl.selNeg, ctl.selPost}));
endmodule

// File: rtl/lsAddrGen.sv
module lsAddrGen
  import lsag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              extEnable,
  input  logic [15:0]       hwFirst,
  input  logic [15:0]       hwSecond,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] offVal,
  input  logic              memDone,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [1:0]        xferSize,
  output logic              isLoad,
  output logic [3:0]        rtIdx,
  output logic [3:0]        rnIdx,
  output logic [3:0]        rmIdx,
  output logic              wbValid,
  output logic [3:0]        wbIdx,
  output logic [ADDR_W-1:0] wbData
);
  lsagCtl_t ctl;

  lsagCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .extEnable(extEnable),
    .hwFirst(hwFirst), .hwSecond(hwSecond), .memDone(memDone), .ctl(ctl)
  );

  lsagPath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hwFirst(hwFirst), .hwSecond(hwSecond),
    .baseVal(baseVal), .offVal(offVal), .memDone(memDone),
    .extEnable(extEnable), .inValid(inValid),
    .outValid(outValid), .effAddr(effAddr), .xferSize(xferSize),
    .isLoad(isLoad), .rtIdx(rtIdx), .rnIdx(rnIdx), .rmIdx(rmIdx),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData)
  );
endmodule

// File: tb/lsAddrGen_test.sv
`timescale 1ns/1ps
module lsAddrGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, extEnable = 1'b0, memDone = 1'b0;
  logic [15:0] hwFirst = '0, hwSecond = '0;
  logic [31:0] baseVal = '0, offVal = '0;
  logic        outValid, isLoad, wbValid;
  logic [31:0] effAddr, wbData;
  logic [1:0]  xferSize;
  logic [3:0]  rtIdx, rnIdx, rmIdx, wbIdx;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsAddrGen uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] encTwo(logic [1:0] sc, logic a, logic [1:0] sz,
      logic ld, logic [3:0] rn, logic [3:0] rt, logic [7:0] imm, logic [3:0] rm);
    return {4'b1100, sc, a, 1'b0, 1'b1, sz, ld, rn, rt, imm, rm};
  endfunction

  function automatic logic [31:0] encFam(logic post, logic [2:0] sh, logic [3:0] inc,
      logic [1:0] sz, logic ld, logic [3:0] rn, logic [3:0] rt, logic [3:0] rm);
    return {6'b101001, 1'b0, 1'b0, 1'b0, sz, ld, rn, rt, post, sh, inc, rm};
  endfunction

  // apply one instruction; returns after outputs are registered
  task automatic issue(logic [31:0] enc, logic [31:0] b, logic [31:0] o, logic en);
    @(negedge clk);
    {hwFirst, hwSecond} = enc; baseVal = b; offVal = o; extEnable = en; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); memDone = 1'b1;
    @(negedge clk); memDone = 1'b0;
  endtask

  task automatic tReset();
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 wbValid", {31'b0, wbValid}, 32'd0);
  endtask

  task automatic tTwoAdd();
    issue(encTwo(2'd2, 1'b1, 2'b10, 1'b1, 4'd3, 4'd7, 8'h10, 4'd9), 32'h1000, 32'd5, 1'b1);
    check("R10 outValid", {31'b0, outValid}, 32'd1);
    check("R2 addr", effAddr, 32'h1024);
    check("R10 fields", {20'b0, xferSize, isLoad, rtIdx, rnIdx, rmIdx}, {20'b0, 2'b10, 1'b1, 4'd7, 4'd3, 4'd9});
    pulseDone();
    check("R8 no wb two-offset", {31'b0, wbValid}, 32'd0);
  endtask

  task automatic tTwoSub();
    issue(encTwo(2'd1, 1'b0, 2'b01, 1'b0, 4'd2, 4'd4, 8'h20, 4'd6), 32'h2000, 32'd3, 1'b1);
    check("R3 addr", effAddr, 32'h1FE6);
    check("R10 store", {31'b0, isLoad}, 32'd0);
  endtask

  task automatic tScale();
    issue(encTwo(2'd0, 1'b1, 2'b00, 1'b1, 4'd1, 4'd1, 8'h00, 4'd1), 32'h500, 32'd7, 1'b1);
    check("R4 scale0", effAddr, 32'h507);
    issue(encTwo(2'd3, 1'b1, 2'b00, 1'b1, 4'd1, 4'd1, 8'h00, 4'd1), 32'h500, 32'd7, 1'b1);
    check("R4 scale3", effAddr, 32'h538);
  endtask

  task automatic tNeg();
    issue(encFam(1'b0, 3'd7, 4'hF, 2'b10, 1'b1, 4'd5, 4'd8, 4'd10), 32'h100, 32'h30, 1'b1);
    check("R5 addr", effAddr, 32'hD0);
    pulseDone();
    check("R8 no wb neg", {31'b0, wbValid}, 32'd0);
  endtask

  task automatic tPost();
    issue(encFam(1'b1, 3'd3, 4'd5, 2'b01, 1'b0, 4'd4, 4'd2, 4'd11), 32'h4000, 32'h10, 1'b1);
    check("R6 addr", effAddr, 32'h4080);
    @(negedge clk);
    check("R7 no wb before done", {31'b0, wbValid}, 32'd0);
    @(negedge clk); memDone = 1'b1;
    @(negedge clk); memDone = 1'b0;
    check("R7 wb strobe", {31'b0, wbValid}, 32'd1);
    check("R7 wb idx", {28'b0, wbIdx}, 32'd11);
    check("R7 wb data", wbData, 32'h15);
    @(negedge clk);
    check("R7 wb single cycle", {31'b0, wbValid}, 32'd0);
  endtask

  task automatic tGate();
    issue(encTwo(2'd1, 1'b1, 2'b10, 1'b1, 4'd3, 4'd7, 8'h10, 4'd9), 32'h1000, 32'd5, 1'b0);
    check("R9 disabled", {31'b0, outValid}, 32'd0);
    issue(32'h0000_0000, 32'h1000, 32'd5, 1'b1);
    check("R9 other opcode", {31'b0, outValid}, 32'd0);
  endtask

  task automatic tWrap();
    issue(encTwo(2'd1, 1'b1, 2'b10, 1'b1, 4'd0, 4'd0, 8'h10, 4'd0), 32'hFFFF_FFF0, 32'd8, 1'b1);
    check("R11 wrap up", effAddr, 32'h10);
    issue(encFam(1'b0, 3'd0, 4'd0, 2'b10, 1'b1, 4'd0, 4'd0, 4'd0), 32'h0, 32'd1, 1'b1);
    check("R11 wrap down", effAddr, 32'hFFFF_FFFF);
    issue(encFam(1'b1, 3'd0, 4'd2, 2'b10, 1'b1, 4'd0, 4'd0, 4'd1), 32'h0, 32'hFFFF_FFFF, 1'b1);
    pulseDone();
    check("R11 inc wrap", wbData, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTwoAdd();
    tTwoSub();
    tScale();
    tNeg();
    tPost();
    tGate();
    tWrap();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule